// File: doc/BRIEF.md
# Single-Bit SD Data Block Receiver

This block takes in one data block from a memory card over a single serial data line, sampled on the rising edge of the card clock. After software or a sequencer pulses `arm`, the receiver watches the line for the low start bit and then collects exactly the number of payload bytes given on `blk_len`. That length must match the block length already agreed with the card. Each completed byte appears on `rx_byte` together with a one-cycle `rx_byte_vld` strobe. The receiver never stalls, so the consumer must take every byte as it arrives.

After the payload, the receiver collects a 16-bit checksum sent as two bytes, and then one closing bit. It computes its own CRC-16 over the payload bits and compares it with the received checksum. It also checks that the closing bit is high. The result is reported on `blk_done`, `crc_err` and `end_err`, and all three hold until the next arm. If the line stays high for `wait_limit` sampled cycles after arming, the receiver raises `no_start` and returns to idle without reporting a block.

Top module: `sd_blk_rx`

## Requirements
- R1: After a synchronous active-low reset, `rx_byte_vld`, `blk_done`, `crc_err`, `end_err` and `no_start` are all 0 and the receiver is idle.
- R2: After arming, the receiver samples `sd_dat` from the first rising edge after the `arm` edge onward. A high sample is ignored as idle line. The first low sample is the start bit, and no byte is produced before it.
- R3: After the start bit, exactly `blk_len` bytes are produced, MSB first (the first bit on the line is bit 7). Each byte is valid for exactly one cycle, in the cycle after its eighth bit is sampled.
- R4: The checksum is CRC-16 with polynomial 0x1021 (x^16+x^12+x^5+1) and initial value 0. It is computed MSB first over the payload bits only and compared with the 16 bits that follow the payload, first bit = bit 15. On a mismatch `crc_err` is 1; on a match it is 0.
- R5: The bit after the checksum must be 1. If it is 0, `end_err` is 1; otherwise `end_err` is 0.
- R6: `blk_done` rises in the cycle after the closing bit is sampled. It stays high, together with `crc_err` and `end_err`, until the next `arm`. `crc_err` and `end_err` are never 1 while `blk_done` is 0.
- R7: If `wait_limit` consecutive high samples occur after arming with no start bit, `no_start` rises in the cycle after the last of them. The receiver then goes idle and `blk_done` stays 0. A `wait_limit` of 0 acts as 1.
- R8: An `arm` pulse at any time, including during a block, abandons the current block. In the following cycle it clears `blk_done`, `crc_err`, `end_err` and `no_start`, and it restarts the wait for a start bit.
- R9: With `blk_len` = 0, the checksum follows the start bit directly, no byte is produced, and the expected checksum is 0x0000.
- R10: While idle (not armed, or after a block or timeout has finished), `sd_dat` is ignored: no bytes are produced and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; the data line is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | One-cycle pulse that starts or restarts reception |
| blk_len | input | LEN_W | Payload length in bytes, captured on `arm` |
| wait_limit | input | TMO_W | Maximum number of high samples before the start bit, captured on `arm` |
| sd_dat | input | 1 | Serial data line from the card |
| rx_byte | output | 8 | Most recently assembled payload byte |
| rx_byte_vld | output | 1 | One-cycle strobe marking a new `rx_byte` |
| blk_done | output | 1 | Block fully received; held until next `arm` |
| crc_err | output | 1 | Received checksum differs from the computed one |
| end_err | output | 1 | Closing bit was sampled low |
| no_start | output | 1 | No start bit arrived within `wait_limit` samples |

## Verification
A bit counter that has slipped moves byte boundaries. The bytes then come out shifted at the first strobe, and the closing bit is read from a checksum position, which makes `end_err` or `crc_err` wrong one cycle after the frame ends. A byte counter that is off by one gives one strobe too many or too few, and so misaligns the checksum bits, which shows at `blk_done`. A CRC register that is not cleared at the start, or that also absorbs checksum bits, stays hidden until the single flag check after the closing bit. For that reason the bench compares every frame's flags against a checksum it computes itself. A wait counter that is off by one moves `no_start` by one cycle, and the bench catches this by sampling the cycle before the timeout and the cycle of the timeout.

// File: rtl/sd_rx_pkg.sv
// Shared types for the single-bit SD block receiver.
// Assumes: nothing beyond the IEEE 1800-2017 package rules.
package sd_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_WAIT  = 3'd1,
        RX_DATA  = 3'd2,
        RX_CHK   = 3'd3,
        RX_CLOSE = 3'd4
    } rx_state_t;

    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam int          CRC_BITS  = 16;
    localparam int          BYTE_BITS = 8;

endpackage

// File: rtl/sd_rx_crc16.sv
// Serial CRC-16 accumulator, one bit per clock, MSB first.
// Assumes: clr has priority over en; after clr the value is 0 (the initial value).
module sd_rx_crc16
    import sd_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        bit_in,
    output logic [15:0] crc_q
);

    logic fb;

    // Feedback bit: the top register bit combined with the incoming bit
    assign fb = crc_q[15] ^ bit_in;

    // Clear or advance the checksum register by one bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
    end

    AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == 16'h0000)); // R4

    AST_CRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc_q)); // R4

endmodule

// File: rtl/sd_rx_shreg.sv
// Serial-in shift register holding the most recent W line samples.
// Assumes: bit_in arrives MSB first, so the oldest sample sits at the top.
module sd_rx_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] q
);

    // Shift one sample in at the bottom when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], bit_in};
        end
    end

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q[0] == $past(bit_in))); // R3

endmodule

// File: rtl/sd_rx_ctrl.sv
// Framing sequencer: waits for the start bit, counts payload and checksum
// bits, outputs bytes, and judges the checksum and closing bit.
// Assumes: sh_q holds recent line samples (newest at bit 0), and crc_q is the
// CRC of payload bits only, updated while crc_en is high and cleared by crc_clr.
module sd_rx_ctrl
    import sd_rx_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [TMO_W-1:0] wait_limit,
    input  logic             sd_dat,
    input  logic [15:0]      sh_q,
    input  logic [15:0]      crc_q,
    output logic             crc_clr,
    output logic             crc_en,
    output logic             sh_en,
    output logic [7:0]       rx_byte,
    output logic             rx_byte_vld,
    output logic             blk_done,
    output logic             crc_err,
    output logic             end_err,
    output logic             no_start
);

    localparam int BITC_W = $clog2(CRC_BITS);

    rx_state_t          st;
    logic [LEN_W-1:0]   len_q;
    logic [TMO_W-1:0]   lim_q;
    logic [TMO_W-1:0]   wcnt;
    logic [TMO_W:0]     wnext;
    logic [BITC_W-1:0]  bitc;
    logic [LEN_W-1:0]   bytec;
    logic               last_byte_bit;
    logic               last_chk_bit;

    // Wait count after this sample, one bit wider so it cannot wrap
    assign wnext         = {1'b0, wcnt} + (TMO_W+1)'(1);
    assign last_byte_bit = (bitc == BITC_W'(BYTE_BITS - 1));
    assign last_chk_bit  = (bitc == BITC_W'(CRC_BITS - 1));

    // Datapath enables: the CRC is cleared while waiting and advanced on payload only
    always_comb begin
        crc_clr = (st == RX_WAIT);
        crc_en  = (st == RX_DATA);
        sh_en   = (st == RX_DATA) || (st == RX_CHK);
    end

    // Frame state, counters and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= RX_IDLE;
            len_q       <= '0;
            lim_q       <= '0;
            wcnt        <= '0;
            bitc        <= '0;
            bytec       <= '0;
            rx_byte     <= '0;
            rx_byte_vld <= 1'b0;
            blk_done    <= 1'b0;
            crc_err     <= 1'b0;
            end_err     <= 1'b0;
            no_start    <= 1'b0;
        end else begin
            rx_byte_vld <= 1'b0;
            if (arm) begin
                st       <= RX_WAIT;
                len_q    <= blk_len;
                lim_q    <= wait_limit;
                wcnt     <= '0;
                blk_done <= 1'b0;
                crc_err  <= 1'b0;
                end_err  <= 1'b0;
                no_start <= 1'b0;
            end else begin
                case (st)
                    RX_WAIT: begin
                        if (!sd_dat) begin
                            bitc  <= '0;
                            bytec <= '0;
                            st    <= (len_q == '0) ? RX_CHK : RX_DATA;
                        end else if (wnext >= {1'b0, lim_q}) begin
                            no_start <= 1'b1;
                            st       <= RX_IDLE;
                        end else begin
                            wcnt <= wnext[TMO_W-1:0];
                        end
                    end
                    RX_DATA: begin
                        if (last_byte_bit) begin
                            bitc        <= '0;
                            rx_byte     <= {sh_q[6:0], sd_dat};
                            rx_byte_vld <= 1'b1;
                            if (bytec == len_q - LEN_W'(1)) begin
                                st <= RX_CHK;
                            end else begin
                                bytec <= bytec + LEN_W'(1);
                            end
                        end else begin
                            bitc <= bitc + BITC_W'(1);
                        end
                    end
                    RX_CHK: begin
                        bitc <= bitc + BITC_W'(1);
                        if (last_chk_bit) begin
                            st <= RX_CLOSE;
                        end
                    end
                    RX_CLOSE: begin
                        blk_done <= 1'b1;
                        end_err  <= !sd_dat;
                        crc_err  <= (sh_q != crc_q);
                        st       <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    AST_VLD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_vld |-> ($past(st) == RX_DATA)); // R3

    AST_BYTE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_DATA) |-> (bytec < len_q)); // R3

    AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err || end_err) |-> blk_done); // R6

    AST_DONE_NOT_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_done && no_start)); // R7

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!blk_done && !crc_err && !end_err && !no_start)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && !arm) |=> ($stable(blk_done) && !rx_byte_vld)); // R10

endmodule

// File: rtl/sd_blk_rx.sv
// Top of the single-bit SD data block receiver: joins the sequencer, the
// sample shift register and the CRC-16 accumulator.
// Assumes: sd_dat is already synchronous to clk; blk_len matches the card.
module sd_blk_rx
    import sd_rx_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [TMO_W-1:0] wait_limit,
    input  logic             sd_dat,
    output logic [7:0]       rx_byte,
    output logic             rx_byte_vld,
    output logic             blk_done,
    output logic             crc_err,
    output logic             end_err,
    output logic             no_start
);

    logic        crc_clr;
    logic        crc_en;
    logic        sh_en;
    logic [15:0] sh_q;
    logic [15:0] crc_q;

    sd_rx_ctrl #(
        .LEN_W (LEN_W),
        .TMO_W (TMO_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .blk_len     (blk_len),
        .wait_limit  (wait_limit),
        .sd_dat      (sd_dat),
        .sh_q        (sh_q),
        .crc_q       (crc_q),
        .crc_clr     (crc_clr),
        .crc_en      (crc_en),
        .sh_en       (sh_en),
        .rx_byte     (rx_byte),
        .rx_byte_vld (rx_byte_vld),
        .blk_done    (blk_done),
        .crc_err     (crc_err),
        .end_err     (end_err),
        .no_start    (no_start)
    );

    sd_rx_shreg #(
        .W (CRC_BITS)
    ) shreg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (sh_en),
        .bit_in (sd_dat),
        .q      (sh_q)
    );

    sd_rx_crc16 crc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_in (sd_dat),
        .crc_q  (crc_q)
    );

endmodule

// File: tb/sd_blk_rx_tb_top.sv
// Directed bench for sd_blk_rx: one task per scenario, each checking itself.
module sd_blk_rx_tb_top;

    localparam int CLK_P = 10;
    localparam int LEN_W = 12;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic [TMO_W-1:0] wait_limit = '0;
    logic             sd_dat = 1'b1;
    logic [7:0]       rx_byte;
    logic             rx_byte_vld;
    logic             blk_done;
    logic             crc_err;
    logic             end_err;
    logic             no_start;

    int checks = 0;
    int errs = 0;
    logic [7:0] tx [0:63];
    logic [7:0] rxd [0:63];
    int rx_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    sd_blk_rx #(.LEN_W(LEN_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .blk_len(blk_len),
        .wait_limit(wait_limit), .sd_dat(sd_dat), .rx_byte(rx_byte),
        .rx_byte_vld(rx_byte_vld), .blk_done(blk_done), .crc_err(crc_err),
        .end_err(end_err), .no_start(no_start)
    );

    // Byte capture, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_byte_vld && rx_cnt < 64) begin
            rxd[rx_cnt] = rx_byte;
        end
        if (rx_byte_vld) rx_cnt = rx_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic f = c[15] ^ tx[i][b];
                c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
            end
        end
        return c;
    endfunction

    task automatic put_bit(input logic b);
        sd_dat = b;
        @(negedge clk);
    endtask

    task automatic do_arm(input int len, input int lim);
        blk_len = LEN_W'(len);
        wait_limit = TMO_W'(lim);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        rx_cnt = 0;
    endtask

    // Idle highs, start bit, payload, checksum, closing bit
    task automatic send_frame(input int len, input logic [15:0] crc_xor, input logic endb);
        logic [15:0] c = crc_of(len) ^ crc_xor;
        repeat (4) put_bit(1'b1);
        put_bit(1'b0);
        for (int i = 0; i < len; i++)
            for (int b = 7; b >= 0; b--) put_bit(tx[i][b]);
        for (int b = 15; b >= 0; b--) put_bit(c[b]);
        put_bit(endb);
        sd_dat = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 vld", rx_byte_vld, 0);
        chk("R1 done", blk_done, 0);
        chk("R1 flags", {crc_err, end_err, no_start}, 0);
    endtask

    task automatic t_idle_ignore();
        rx_cnt = 0;
        for (int i = 0; i < 30; i++) put_bit(i[1]);
        sd_dat = 1'b1;
        chk("R10 bytes", rx_cnt, 0);
        chk("R10 done", blk_done, 0);
    endtask

    task automatic t_good(input int len, input int seed);
        for (int i = 0; i < len; i++) tx[i] = 8'(seed + i * 37);
        do_arm(len, 1000);
        repeat (6) put_bit(1'b1);
        chk("R2 no byte before start", rx_cnt, 0);
        send_frame(len, 16'h0000, 1'b1);
        chk("R3 byte count", rx_cnt, len);
        for (int i = 0; i < len; i++) chk("R3 byte value", rxd[i], tx[i]);
        chk("R6 done", blk_done, 1);
        chk("R4 crc ok", crc_err, 0);
        chk("R5 end ok", end_err, 0);
        repeat (5) put_bit(1'b0);
        sd_dat = 1'b1;
        chk("R6 done held", blk_done, 1);
        chk("R10 no bytes after block", rx_cnt, len);
    endtask

    task automatic t_bad_crc();
        for (int i = 0; i < 3; i++) tx[i] = 8'hC3 ^ 8'(i);
        do_arm(3, 1000);
        send_frame(3, 16'h0400, 1'b1);
        chk("R4 crc mismatch", crc_err, 1);
        chk("R5 end clean", end_err, 0);
        chk("R6 done", blk_done, 1);
    endtask

    task automatic t_bad_end();
        tx[0] = 8'h5A; tx[1] = 8'h01;
        do_arm(2, 1000);
        send_frame(2, 16'h0000, 1'b0);
        chk("R5 end error", end_err, 1);
        chk("R4 crc still ok", crc_err, 0);
    endtask

    task automatic t_timeout();
        sd_dat = 1'b1;
        do_arm(4, 6);
        repeat (5) @(negedge clk);
        chk("R7 not yet", no_start, 0);
        @(negedge clk);
        chk("R7 timeout", no_start, 1);
        chk("R7 no done", blk_done, 0);
        repeat (3) put_bit(1'b0);
        sd_dat = 1'b1;
        chk("R10 ignored after timeout", rx_cnt, 0);
    endtask

    task automatic t_abort();
        tx[0] = 8'hFF; tx[1] = 8'h80;
        do_arm(2, 1000);
        send_frame(2, 16'h0001, 1'b0);
        chk("R4 setup", {crc_err, end_err}, 2'b11);
        do_arm(4, 1000);
        chk("R8 flags cleared", {blk_done, crc_err, end_err, no_start}, 0);
        put_bit(1'b0);
        for (int i = 0; i < 10; i++) put_bit(i[0]);
        tx[0] = 8'h3C; tx[1] = 8'hE7;
        do_arm(2, 1000);
        send_frame(2, 16'h0000, 1'b1);
        chk("R8 count after restart", rx_cnt, 2);
        chk("R8 byte0", rxd[0], 8'h3C);
        chk("R8 byte1", rxd[1], 8'hE7);
        chk("R8 clean result", {blk_done, crc_err, end_err}, 3'b100);
    endtask

    task automatic t_len0();
        do_arm(0, 1000);
        send_frame(0, 16'h0000, 1'b1);
        chk("R9 done", blk_done, 1);
        chk("R9 zero crc ok", crc_err, 0);
        chk("R9 no bytes", rx_cnt, 0);
        do_arm(0, 1000);
        send_frame(0, 16'h1234, 1'b1);
        chk("R9 nonzero crc err", crc_err, 1);
    endtask

    initial begin
        #(CLK_P * 100000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_good(4, 8'h96);
        t_good(1, 8'hA5);
        t_good(16, 8'h01);
        t_bad_crc();
        t_bad_end();
        t_timeout();
        t_abort();
        t_len0();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule